// File: doc/BRIEF.md
# Consecutive Overcurrent Latch-Off Counter

This block protects a synchronous buck power stage against a short circuit or a sustained overload. At the end of each low-side on interval, a strobe marks the point where the current is sensed. At that point the block samples a digital comparator flag. The flag is high when the switch node has fallen below the programmed trip voltage while the low-side switch conducts.

Each sampled trip adds one to a count of consecutive trips. A clean sample returns the count to zero. When the count reaches its limit (seven by default), the block sets a fault latch. The latch withdraws the drive enable, which stops the PWM logic and turns off both the high-side and the low-side switch. Only a power-on reset clears the latch.

Samples are taken only while the converter is running. While the converter is disabled or held in undervoltage lockout, the strobe is ignored, so that no false counts occur.

Top module: `ocp_trip_latch`

## Requirements
- R1: While `por_n` is low, and right after it rises, `trip_count` is 0, `fault` is 0 and `drive_en` is 1.
- R2: A clock edge with `sense_strobe`=1, `conv_active`=1, `fault`=0 and `oc_flag`=1 raises `trip_count` by exactly one, as seen after that edge, provided the limit is not reached.
- R3: A clock edge with `sense_strobe`=1, `conv_active`=1, `fault`=0 and `oc_flag`=0 sets `trip_count` to 0.
- R4: `oc_flag` has no effect on `trip_count` or `fault` in a cycle where `sense_strobe` is 0.
- R5: The sampled trip that brings the count to TRIP_LIMIT (default 7) sets `fault` at that same edge, and `trip_count` then reads TRIP_LIMIT.
- R6: Once `fault` is 1, it stays 1 and `trip_count` holds its value whatever the strobe and the flag do, until `por_n` goes low.
- R7: `drive_en` is 0 exactly when `fault` is 1, which turns off the PWM and both switches.
- R8: While `conv_active` is 0, strobes are ignored: `trip_count` and `fault` keep their values.
- R9: Driving `por_n` low clears a latched fault and the count.
- R10: `trip_count` never exceeds TRIP_LIMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| conv_active | input | 1 | Converter enabled and out of undervoltage lockout |
| sense_strobe | input | 1 | One-cycle pulse at the end of the low-side on interval |
| oc_flag | input | 1 | Comparator: switch node below trip voltage |
| trip_count | output | CNT_W | Current number of consecutive trips |
| fault | output | 1 | Latched overcurrent fault |
| drive_en | output | 1 | Permission for PWM and both gate drivers |

## Verification
The assertions take for granted that the strobe is a single-cycle pulse. They also assume that `oc_flag` and `conv_active` are synchronous to `clk`, and that `por_n` is the only path out of a fault. The bench changes every input at the falling clock edge. It raises the strobe for exactly one cycle per sample, and it clears a fault only through `por_n`. It reads the outputs at the next falling edge, one register stage after each sample.

// File: rtl/ocp_trip_latch.sv
module ocp_trip_latch #(
  parameter int TRIP_LIMIT = 7,
  localparam int CNT_W = $clog2(TRIP_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             conv_active,
  input  logic             sense_strobe,
  input  logic             oc_flag,
  output logic [CNT_W-1:0] trip_count,
  output logic             fault,
  output logic             drive_en
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TRIP_LIMIT);

  logic take_sample;
  logic at_last;

  assign take_sample = sense_strobe && conv_active && !fault;
  assign at_last     = (trip_count == LIMIT - 1'b1);
  assign drive_en    = !fault;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      trip_count <= '0;
      fault      <= 1'b0;
    end else if (take_sample) begin
      if (oc_flag) begin
        trip_count <= trip_count + 1'b1;
        if (at_last) fault <= 1'b1;
      end else begin
        trip_count <= '0;
      end
    end
  end

  p_inc_r2: assert property (@(posedge clk) disable iff (!por_n)
    sense_strobe && conv_active && !fault && oc_flag && trip_count < LIMIT - 1'b1
    |=> trip_count == $past(trip_count) + 1'b1 && !fault);

  p_clear_r3: assert property (@(posedge clk) disable iff (!por_n)
    sense_strobe && conv_active && !fault && !oc_flag |=> trip_count == '0);

  p_idle_r4: assert property (@(posedge clk) disable iff (!por_n)
    !sense_strobe |=> $stable(trip_count) && $stable(fault));

  p_trip_r5: assert property (@(posedge clk) disable iff (!por_n)
    sense_strobe && conv_active && !fault && oc_flag && trip_count == LIMIT - 1'b1
    |=> fault && trip_count == LIMIT);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!por_n)
    fault |=> fault && $stable(trip_count));

  p_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
    !conv_active |=> $stable(trip_count) && $stable(fault));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!por_n)
    trip_count <= LIMIT);

endmodule

// File: tb/test_ocp_trip_latch.sv
module test_ocp_trip_latch;
  localparam int CLK_PERIOD = 10;
  localparam int LIM = 7;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic conv_active = 1'b0;
  logic sense_strobe = 1'b0;
  logic oc_flag = 1'b0;
  logic [2:0] trip_count;
  logic fault;
  logic drive_en;
  int checks = 0;
  int fails = 0;

  ocp_trip_latch #(.TRIP_LIMIT(LIM)) i_ocp_trip_latch (
    .clk(clk), .por_n(por_n), .conv_active(conv_active),
    .sense_strobe(sense_strobe), .oc_flag(oc_flag),
    .trip_count(trip_count), .fault(fault), .drive_en(drive_en));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sample(input logic f);
    @(negedge clk);
    sense_strobe = 1'b1;
    oc_flag = f;
    @(negedge clk);
    sense_strobe = 1'b0;
    oc_flag = 1'b0;
  endtask

  task automatic do_por();
    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    conv_active = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 count", trip_count, 0);
    check("R1 fault", fault, 0);
    check("R1 drive_en", drive_en, 1);
  endtask

  task automatic t_count_and_clear();
    sample(1'b1);
    check("R2 first trip", trip_count, 1);
    sample(1'b1);
    sample(1'b1);
    check("R2 third trip", trip_count, 3);
    sample(1'b0);
    check("R3 clean sample clears", trip_count, 0);
  endtask

  task automatic t_flag_no_strobe();
    sample(1'b1);
    @(negedge clk);
    oc_flag = 1'b1;
    repeat (3) @(negedge clk);
    oc_flag = 1'b0;
    @(negedge clk);
    check("R4 flag without strobe", trip_count, 1);
    check("R4 no fault", fault, 0);
    sample(1'b0);
  endtask

  task automatic t_inactive();
    sample(1'b1);
    sample(1'b1);
    @(negedge clk);
    conv_active = 1'b0;
    sample(1'b1);
    sample(1'b0);
    check("R8 held while inactive", trip_count, 2);
    @(negedge clk);
    conv_active = 1'b1;
    sample(1'b0);
  endtask

  task automatic t_latch();
    for (int k = 0; k < LIM - 1; k++) sample(1'b1);
    check("R5 one short of limit", trip_count, LIM - 1);
    check("R5 no fault yet", fault, 0);
    sample(1'b1);
    check("R5 fault at limit", fault, 1);
    check("R5 count at limit", trip_count, LIM);
    check("R7 drive off", drive_en, 0);
    sample(1'b0);
    sample(1'b1);
    check("R6 fault sticky", fault, 1);
    check("R6 count held", trip_count, LIM);
    check("R10 no overflow", trip_count, LIM);
    do_por();
    check("R9 fault cleared", fault, 0);
    check("R9 count cleared", trip_count, 0);
    check("R7 drive back", drive_en, 1);
  endtask

  task automatic t_interrupted();
    for (int k = 0; k < LIM - 1; k++) sample(1'b1);
    sample(1'b0);
    sample(1'b1);
    check("R3 run broken, no fault", fault, 0);
    check("R3 count restarted", trip_count, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    por_n = 1'b1;
    @(negedge clk);
    t_reset();
    conv_active = 1'b1;
    t_count_and_clear();
    t_flag_no_strobe();
    t_inactive();
    t_latch();
    t_interrupted();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule